// File: doc/BRIEF.md
# SPI Host with Command-Stream FIFO

This block is a memory-mapped SPI host. Software writes 32-bit words into one transmit queue. Each word is either a data byte to shift out or a chip-select command. Because both kinds of word share the same queue, a sequence of select, transfer and deselect runs in exactly the order it was written. The CPU does not need to poll between steps.

A serial engine pops words one at a time, in order. For a chip-select command it updates the eight active-low select lines. For a data byte it runs one 8-bit transfer in the chosen clock-polarity/phase mode and places the received byte in a receive queue.

A control/status register sets the bit-clock rate, the mode and the interrupt enables. It also reports the queue and engine status and the queue depth. A single level interrupt summarises the enabled conditions.

The register interface is a pair of strobes with a one-bit address:
- address 0 is the control/status register;
- address 1 is the data register (write pushes the transmit queue, read pops the receive queue).

Top module: `spi_cmd_host`

## Requirements
- R1: A word written to address 1 with bit 31 clear is a data word: its bits 7:0 are shifted out on `mosi`, most significant bit first, as one 8-bit transfer producing 8 `sclk` cycles.
- R2: A word written to address 1 with bit 31 set is a select command. Bits 2:0 give the line index. If bit 3 is 1, `cs_n[index]` goes low and every other line goes high. If bit 3 is 0, all lines go high together. After reset all lines are high.
- R3: Select commands and data words take effect strictly in the order written; a select change never happens during a transfer.
- R4: The byte sampled from `miso` during a transfer is pushed into the receive queue when the transfer ends. A read of address 1 returns the oldest byte in bits 7:0 and removes it. A read of an empty queue returns zero.
- R5: Control bit 2 (polarity) sets the idle level of `sclk`. Control bit 1 (phase) chooses when `miso` is sampled: 0 samples on the first edge of each bit, 1 samples on the second edge. All four combinations produce correct data in both directions.
- R6: In normal mode the `sclk` half-period is B × (1 + D) system clocks. D is control bits 9:6. B comes from control bits 5:3: code 0..7 gives 2, 4, 8, 64, 128, 1024, 2048, 4096. Setting control bit 10 forces a half-period of one clock.
- R7: Reading address 0 returns the writable fields (bits 1..10, 20, 22, 23) as last written, plus read-only status:
  - bit 16: receive queue not empty;
  - bits 27:24: log2 of the queue depth;
  - bit 30: any select line low;
  - bit 31: engine shifting or transmit queue not empty.

  All other bits read zero, and writes to read-only or reserved bits have no effect.
- R8: `irq` is high (one clock after the condition) while any enabled condition holds:
  - bit 20: receive queue not empty;
  - bit 22: transmit queue holds fewer than half its depth;
  - bit 23: transmit queue empty and engine idle.
- R9: A data-register write while the transmit queue is full is dropped and does not disturb the queued words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops receive queue at address 1) |
| addr | input | 1 | 0 selects control/status, 1 selects data |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low select lines |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted queue pointer or count shows at the ports as a wrong, repeated or missing byte on `mosi`, or in the next data-register read. The bench observes this at the byte boundary where it happens, through a bench-side serial peripheral that records every received byte together with the select lines active at that moment.

A wrong bit or edge counter in the engine shifts the bit alignment, which shows in the byte captured for that same transfer. A wrong rate counter changes the measured half-period on the very first `sclk` toggle.

A stale select register or interrupt term shows within one or two clocks on `cs_n`, `irq` or the status bits.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // control/status bit positions
  localparam int CTRL_CPHA    = 1;
  localparam int CTRL_CPOL    = 2;
  localparam int CTRL_PRSC_LO = 3;
  localparam int CTRL_CDIV_LO = 6;
  localparam int CTRL_HS      = 10;
  localparam int STAT_RX_AV   = 16;
  localparam int IEN_RX       = 20;
  localparam int IEN_TXHALF   = 22;
  localparam int IEN_IDLE     = 23;
  localparam int STAT_DEPTH   = 24;
  localparam int STAT_CS_ACT  = 30;
  localparam int STAT_BUSY    = 31;

  // data word layout
  localparam int WORD_CMD  = 31;
  localparam int CMD_EN    = 3;
  localparam int BYTE_W    = 8;
  localparam int TXQ_W     = BYTE_W + 1;

  // half-period counter width: 4096 * 16 needs 17 bits
  localparam int BASE_W = 13;
  localparam int HALF_W = 17;

  typedef struct packed {
    logic       cpha;
    logic       cpol;
    logic [2:0] prsc;
    logic [3:0] cdiv;
    logic       hs;
  } spi_cfg_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_DONE  = 2'd2
  } eng_state_t;

  function automatic logic [BASE_W-1:0] base_div(input logic [2:0] code);
    logic [BASE_W-1:0] r;
    case (code)
      3'd0:    r = 13'd2;
      3'd1:    r = 13'd4;
      3'd2:    r = 13'd8;
      3'd3:    r = 13'd64;
      3'd4:    r = 13'd128;
      3'd5:    r = 13'd1024;
      3'd6:    r = 13'd2048;
      default: r = 13'd4096;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [WIDTH-1:0]         push_data,
  input  logic                     pop,
  output logic [WIDTH-1:0]         head,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = wr_q + AW'(1);
    if (do_pop)  rd_d = rd_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // R9
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)));

  // R4
  pop_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/spi_cmd_clkgen.sv
module spi_cmd_clkgen
  import spi_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  spi_cfg_t cfg,
  output logic     tick
);
  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cfg.hs) half = HALF_W'(1);
    else        half = HALF_W'(base_div(cfg.prsc)) * HALF_W'(cfg.cdiv + 5'd1);
  end

  assign tick = run && (cnt_q == half - HALF_W'(1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  normal_rate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg.hs) |=> !tick);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int NCS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spi_cfg_t          cfg,
  input  logic              txq_empty,
  input  logic [TXQ_W-1:0]  txq_head,
  output logic              txq_pop,
  input  logic              tick,
  output logic              run,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic              busy
);
  localparam int SEL_W  = $clog2(NCS);
  localparam int EDGES  = 2 * BYTE_W;
  localparam int EDGE_W = $clog2(EDGES);

  eng_state_t        st_q, st_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [BYTE_W-1:0] txr_q, txr_d, rxr_q, rxr_d;
  logic              mosi_q, mosi_d, sclk_q, sclk_d;
  logic [NCS-1:0]    cs_q, cs_d;
  logic              sample;
  logic              is_cmd;

  assign is_cmd = txq_head[TXQ_W-1];

  always_comb begin
    st_d    = st_q;
    edge_d  = edge_q;
    txr_d   = txr_q;
    rxr_d   = rxr_q;
    mosi_d  = mosi_q;
    sclk_d  = sclk_q;
    cs_d    = cs_q;
    txq_pop = 1'b0;
    rx_push = 1'b0;
    sample  = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        sclk_d = cfg.cpol;
        if (!txq_empty) begin
          txq_pop = 1'b1;
          if (is_cmd) begin
            if (txq_head[CMD_EN]) cs_d = ~(NCS'(1) << txq_head[SEL_W-1:0]);
            else                  cs_d = '1;
          end else begin
            edge_d = '0;
            st_d   = ENG_SHIFT;
            if (cfg.cpha) begin
              txr_d = txq_head[BYTE_W-1:0];
            end else begin
              mosi_d = txq_head[BYTE_W-1];
              txr_d  = {txq_head[BYTE_W-2:0], 1'b0};
            end
          end
        end
      end
      ENG_SHIFT: begin
        if (tick) begin
          sclk_d = ~sclk_q;
          edge_d = edge_q + EDGE_W'(1);
          // even edge count = leading edge of a bit
          sample = (edge_q[0] == cfg.cpha);
          if (sample) begin
            rxr_d = {rxr_q[BYTE_W-2:0], miso};
          end else begin
            mosi_d = txr_q[BYTE_W-1];
            txr_d  = {txr_q[BYTE_W-2:0], 1'b0};
          end
          if (edge_q == EDGE_W'(EDGES - 1)) st_d = ENG_DONE;
        end
      end
      ENG_DONE: begin
        rx_push = 1'b1;
        st_d    = ENG_IDLE;
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      edge_q <= '0;
      txr_q  <= '0;
      rxr_q  <= '0;
      mosi_q <= 1'b0;
      sclk_q <= 1'b0;
      cs_q   <= '1;
    end else begin
      st_q   <= st_d;
      edge_q <= edge_d;
      txr_q  <= txr_d;
      rxr_q  <= rxr_d;
      mosi_q <= mosi_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
    end
  end

  assign run     = (st_q == ENG_SHIFT);
  assign busy    = (st_q != ENG_IDLE);
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign cs_n    = cs_q;
  assign rx_data = rxr_q;

  // R2
  cs_one_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_q));

  // R3
  cs_frozen_in_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ENG_IDLE) |=> $stable(cs_q));

  // R1
  mosi_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_SHIFT && !tick) |=> $stable(mosi_q));

  // R5
  idle_level_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (sclk_q == cfg.cpol));

endmodule

// File: rtl/spi_cmd_host.sv
module spi_cmd_host
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int NCS        = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic           addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n,
  output logic           irq
);
  localparam int FIFO_AW = $clog2(FIFO_DEPTH);
  localparam int CNT_W   = FIFO_AW + 1;

  spi_cfg_t cfg_q, cfg_d;
  logic     ie_rx_q, ie_rx_d, ie_txh_q, ie_txh_d, ie_idle_q, ie_idle_d;
  logic     irq_q, irq_d;

  logic              tx_push, tx_pop, tx_empty;
  logic [TXQ_W-1:0]  tx_head;
  logic [CNT_W-1:0]  tx_count;
  logic              rx_push, rx_pop, rx_empty;
  logic [BYTE_W-1:0] rx_wdata, rx_head;
  logic              tick, run, eng_busy;
  logic [31:0]       ctrl_rd;

  logic              tx_full_unused, rx_full_unused;
  logic [CNT_W-1:0]  rx_count_unused;
  logic              wdata_unused;

  assign wdata_unused = ^{wdata[0], wdata[19:11], wdata[21], wdata[30:24]};

  assign tx_push = wr_en && addr;
  assign rx_pop  = rd_en && addr;

  // configuration register
  always_comb begin
    cfg_d     = cfg_q;
    ie_rx_d   = ie_rx_q;
    ie_txh_d  = ie_txh_q;
    ie_idle_d = ie_idle_q;
    if (wr_en && !addr) begin
      cfg_d.cpha = wdata[CTRL_CPHA];
      cfg_d.cpol = wdata[CTRL_CPOL];
      cfg_d.prsc = wdata[CTRL_PRSC_LO +: 3];
      cfg_d.cdiv = wdata[CTRL_CDIV_LO +: 4];
      cfg_d.hs   = wdata[CTRL_HS];
      ie_rx_d    = wdata[IEN_RX];
      ie_txh_d   = wdata[IEN_TXHALF];
      ie_idle_d  = wdata[IEN_IDLE];
    end
  end

  assign irq_d = (ie_rx_q && !rx_empty)
              || (ie_txh_q && (tx_count < CNT_W'(FIFO_DEPTH / 2)))
              || (ie_idle_q && tx_empty && !eng_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      ie_rx_q   <= 1'b0;
      ie_txh_q  <= 1'b0;
      ie_idle_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      ie_rx_q   <= ie_rx_d;
      ie_txh_q  <= ie_txh_d;
      ie_idle_q <= ie_idle_d;
      irq_q     <= irq_d;
    end
  end

  always_comb begin
    ctrl_rd                        = '0;
    ctrl_rd[CTRL_CPHA]             = cfg_q.cpha;
    ctrl_rd[CTRL_CPOL]             = cfg_q.cpol;
    ctrl_rd[CTRL_PRSC_LO +: 3]     = cfg_q.prsc;
    ctrl_rd[CTRL_CDIV_LO +: 4]     = cfg_q.cdiv;
    ctrl_rd[CTRL_HS]               = cfg_q.hs;
    ctrl_rd[STAT_RX_AV]            = !rx_empty;
    ctrl_rd[IEN_RX]                = ie_rx_q;
    ctrl_rd[IEN_TXHALF]            = ie_txh_q;
    ctrl_rd[IEN_IDLE]              = ie_idle_q;
    ctrl_rd[STAT_DEPTH +: 4]       = 4'(FIFO_AW);
    ctrl_rd[STAT_CS_ACT]           = (cs_n != '1);
    ctrl_rd[STAT_BUSY]             = eng_busy || !tx_empty;
  end

  assign rdata = addr ? {24'b0, (rx_empty ? 8'h00 : rx_head)} : ctrl_rd;
  assign irq   = irq_q;

  spi_cmd_fifo #(.WIDTH(TXQ_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (tx_push),
    .push_data ({wdata[WORD_CMD], wdata[BYTE_W-1:0]}),
    .pop       (tx_pop),
    .head      (tx_head),
    .empty     (tx_empty),
    .full      (tx_full_unused),
    .count     (tx_count)
  );

  spi_cmd_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_data (rx_wdata),
    .pop       (rx_pop),
    .head      (rx_head),
    .empty     (rx_empty),
    .full      (rx_full_unused),
    .count     (rx_count_unused)
  );

  spi_cmd_clkgen u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .cfg   (cfg_q),
    .tick  (tick)
  );

  spi_cmd_engine #(.NCS(NCS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg_q),
    .txq_empty (tx_empty),
    .txq_head  (tx_head),
    .txq_pop   (tx_pop),
    .tick      (tick),
    .run       (run),
    .sclk      (sclk),
    .mosi      (mosi),
    .miso      (miso),
    .cs_n      (cs_n),
    .rx_push   (rx_push),
    .rx_data   (rx_wdata),
    .busy      (eng_busy)
  );

endmodule

// File: tb/spi_cmd_host_bench.sv
module spi_cmd_host_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, miso, irq;
  logic [7:0]  cs_n;

  int n_checks = 0, n_err = 0, cyc = 0;
  bit finished = 0;

  // bench-side serial peripheral
  logic       tb_cpol = 0, tb_cpha = 0;
  logic [7:0] s_pat = '0, s_shift = '0;
  int         lead_cnt = 0, samp_cnt = 0, n_got = 0, s_bi;
  logic [7:0] got [64];
  logic [7:0] got_cs [64];

  spi_cmd_host u_spi_cmd_host (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic slave_sample();
    s_shift = {s_shift[6:0], mosi};
    samp_cnt++;
    if (samp_cnt == 8) begin
      got[n_got]    = s_shift;
      got_cs[n_got] = cs_n;
      n_got++;
      samp_cnt = 0;
      lead_cnt = 0;
    end
  endtask

  always @(sclk) begin
    if (!$isunknown(sclk) && (cs_n != 8'hFF)) begin
      if (sclk != tb_cpol) begin
        lead_cnt++;
        if (!tb_cpha) slave_sample();
      end else if (tb_cpha) begin
        slave_sample();
      end
    end
  end

  always @* begin
    s_bi = tb_cpha ? 8 - lead_cnt : 7 - lead_cnt;
    miso = (s_bi >= 0 && s_bi <= 7) ? s_pat[s_bi[2:0]] : 1'b0;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 50000; i++) begin
      bus_rd(1'b0, v);
      if (!v[31]) break;
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input logic cpha, input logic cpol,
      input logic [2:0] prsc, input logic [3:0] cdiv, input logic hs,
      input logic ie_rx, input logic ie_txh, input logic ie_idle);
    return {8'b0, ie_idle, ie_txh, 1'b0, ie_rx, 9'b0, hs, cdiv, prsc, cpol, cpha, 1'b0};
  endfunction

  task automatic set_ctrl(input logic [31:0] v);
    tb_cpha = v[1];
    tb_cpol = v[2];
    bus_wr(1'b0, v);
  endtask

  task automatic slave_arm(input logic [7:0] pat);
    s_pat = pat; lead_cnt = 0; samp_cnt = 0;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    chk("R2 reset cs_n", {24'b0, cs_n}, 32'hFF);
    chk("R8 reset irq", {31'b0, irq}, 0);
    chk("R5 reset sclk", {31'b0, sclk}, 0);
    bus_rd(1'b0, v);
    chk("R7 reset status", v, 32'h0300_0000);
    bus_rd(1'b1, v);
    chk("R4 empty read", v, 0);
  endtask

  task automatic test_cs();
    logic [31:0] v;
    bus_wr(1'b1, 32'h8000_000D); wait_idle();
    chk("R2 select line 5", {24'b0, cs_n}, 32'hDF);
    bus_rd(1'b0, v);
    chk("R7 cs active bit", {31'b0, v[30]}, 1);
    bus_wr(1'b1, 32'h8000_000F); wait_idle();
    chk("R2 select line 7", {24'b0, cs_n}, 32'h7F);
    bus_wr(1'b1, 32'h8000_0006); wait_idle();
    chk("R2 deselect all", {24'b0, cs_n}, 32'hFF);
    bus_rd(1'b0, v);
    chk("R7 cs inactive bit", {31'b0, v[30]}, 0);
  endtask

  task automatic test_modes();
    logic [7:0]  tx [4] = '{8'hA5, 8'h3C, 8'h96, 8'h01};
    logic [7:0]  sp [4] = '{8'h5A, 8'hC3, 8'h81, 8'hFE};
    logic [31:0] v;
    int g0;
    for (int m = 0; m < 4; m++) begin
      set_ctrl(mk_ctrl(m[0], m[1], 3'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0));
      repeat (2) @(negedge clk);
      chk("R5 idle level", {31'b0, sclk}, {31'b0, m[1]});
      slave_arm(sp[m]);
      g0 = n_got;
      bus_wr(1'b1, 32'h8000_0008);
      bus_wr(1'b1, {24'b0, tx[m]});
      bus_wr(1'b1, 32'h8000_0000);
      wait_idle();
      chk("R1 byte count", n_got - g0, 1);
      chk("R1 mosi byte", {24'b0, got[g0]}, {24'b0, tx[m]});
      bus_rd(1'b1, v);
      chk("R5 miso byte via R4 read", v, {24'b0, sp[m]});
      bus_rd(1'b1, v);
      chk("R4 read after pop", v, 0);
      chk("R5 idle after transfer", {31'b0, sclk}, {31'b0, m[1]});
    end
  endtask

  task automatic test_order();
    logic [31:0] v;
    int g0;
    set_ctrl(mk_ctrl(1'b0, 1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    slave_arm(8'h00);
    g0 = n_got;
    bus_wr(1'b1, 32'h8000_000B);
    bus_wr(1'b1, 32'h0000_0011);
    bus_wr(1'b1, 32'h8000_000E);
    bus_wr(1'b1, 32'h0000_0022);
    bus_wr(1'b1, 32'h8000_0000);
    wait_idle();
    chk("R3 first byte", {24'b0, got[g0]}, 32'h11);
    chk("R3 select during first", {24'b0, got_cs[g0]}, 32'hF7);
    chk("R3 second byte", {24'b0, got[g0+1]}, 32'h22);
    chk("R3 select during second", {24'b0, got_cs[g0+1]}, 32'hBF);
    chk("R3 final deselect", {24'b0, cs_n}, 32'hFF);
    bus_rd(1'b1, v); bus_rd(1'b1, v);
  endtask

  task automatic measure(input logic [31:0] ctl, input int exp, input string req);
    int t0, t1;
    logic [31:0] v;
    set_ctrl(ctl);
    bus_wr(1'b1, 32'h0000_0055);
    @(sclk); t0 = cyc;
    @(sclk); t1 = cyc;
    chk(req, t1 - t0, exp);
    wait_idle();
    bus_rd(1'b1, v);
  endtask

  task automatic test_rate();
    measure(mk_ctrl(0, 0, 3'd0, 4'd0, 0, 0, 0, 0), 2,  "R6 code0 div0");
    measure(mk_ctrl(0, 0, 3'd1, 4'd2, 0, 0, 0, 0), 12, "R6 code1 div2");
    measure(mk_ctrl(0, 0, 3'd3, 4'd0, 0, 0, 0, 0), 64, "R6 code3 div0");
    measure(mk_ctrl(0, 0, 3'd7, 4'd9, 1, 0, 0, 0), 1,  "R6 high-speed");
  endtask

  task automatic test_irq();
    logic [31:0] v;
    set_ctrl(mk_ctrl(0, 0, 3'd0, 4'd0, 0, 1, 0, 0));
    repeat (2) @(negedge clk);
    chk("R8 rx irq idle", {31'b0, irq}, 0);
    slave_arm(8'h77);
    bus_wr(1'b1, 32'h8000_0008);
    bus_wr(1'b1, 32'h0000_0033);
    bus_wr(1'b1, 32'h8000_0000);
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R8 rx irq raised", {31'b0, irq}, 1);
    bus_rd(1'b0, v);
    chk("R7 rx available", {31'b0, v[16]}, 1);
    bus_rd(1'b1, v);
    chk("R4 received byte", v, 32'h77);
    repeat (2) @(negedge clk);
    chk("R8 rx irq cleared", {31'b0, irq}, 0);
    set_ctrl(mk_ctrl(0, 0, 3'd0, 4'd0, 0, 0, 0, 1));
    repeat (2) @(negedge clk);
    chk("R8 idle irq", {31'b0, irq}, 1);
    set_ctrl(32'h0);
    repeat (2) @(negedge clk);
    chk("R8 all disabled", {31'b0, irq}, 0);
  endtask

  task automatic test_drop();
    logic [31:0] v;
    int g0;
    set_ctrl(mk_ctrl(0, 0, 3'd3, 4'd0, 0, 0, 1, 0));
    slave_arm(8'h00);
    bus_wr(1'b1, 32'h8000_000A);
    wait_idle();
    g0 = n_got;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      wr_en = 1'b1; addr = 1'b1; wdata = 32'h40 + i;
      @(negedge clk);
    end
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 tx half irq low when full", {31'b0, irq}, 0);
    wait_idle();
    chk("R9 bytes sent", n_got - g0, 9);
    chk("R9 first byte", {24'b0, got[g0]}, 32'h40);
    chk("R9 last kept byte", {24'b0, got[g0+8]}, 32'h48);
    repeat (2) @(negedge clk);
    chk("R8 tx half irq high when empty", {31'b0, irq}, 1);
    bus_wr(1'b1, 32'h8000_0000);
    wait_idle();
    for (int i = 0; i < 8; i++) bus_rd(1'b1, v);
    set_ctrl(32'h0);
  endtask

  task automatic test_readback();
    logic [31:0] v;
    set_ctrl(32'h00D0_07FE);
    bus_rd(1'b0, v);
    chk("R7 field readback", v, 32'h03D0_07FE);
    set_ctrl(32'hFFFF_FFFF);
    bus_rd(1'b0, v);
    chk("R7 read-only bits ignored", v, 32'h03D0_07FE);
    set_ctrl(32'h0);
    bus_rd(1'b0, v);
    chk("R7 cleared", v, 32'h0300_0000);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_cs();
    test_modes();
    test_order();
    test_rate();
    test_irq();
    test_drop();
    test_readback();
    finished = 1;
    summary();
    $finish;
  end

endmodule